// File: doc/BRIEF.md
# Timer Compare Channel with Pulse Output

This block is one compare channel that watches a free-running timestamp counter kept outside it. Software arms it with a compare value and picks an output behaviour. When the counter reaches the armed value, the channel latches an event flag. It can raise an interrupt, and it either inverts its output pin or drives a short fixed-length high pulse on it.

The compare value is held in two slots: one armed slot and one queued slot. Software can load the value for the event after next while the current value is still waiting to match. On a match, the queued value moves into the armed slot. A handler that answers each event with one new value therefore keeps a steady train of events going, such as a once-per-second pulse. A match that falls in the same cycle as the counter's period wrap counts only when the wrap-event enable input is set.

Top module: `tcmp_channel`

## Requirements
- R1: After reset, the status/control readback is 0, the interrupt is low, the pin is low and no compare value is armed.
- R2: The status/control word uses these bits: bit 0 is the DMA-request enable (stored and read back only), bits [5:2] are the output mode, bit 6 is the interrupt enable and bit 7 is the event flag. A write updates bits 0, 6 and [5:2] as written.
- R3: The event flag is cleared by writing the word with bit 7 set. Writing bit 7 as 0 leaves the flag as it is. If a match happens in the same cycle as a clearing write, the flag stays set.
- R4: The interrupt output is high exactly when the event flag and the interrupt enable are both set.
- R5: A match happens at a clock edge where the mode is nonzero, a value is armed and the counter input equals the armed value. The flag then reads 1 after that edge.
- R6: In mode 0x5, the pin inverts at every match.
- R7: In mode 0xF, the pin goes high at the match edge and stays high for exactly PULSE_LEN clock cycles. It then returns low.
- R8: A compare write made while the mode is 0, or while no value is armed, goes into the armed slot. The compare readback shows the armed value.
- R9: A compare write made while the mode is nonzero and a value is armed goes into the queued slot. On the next match, the queued value becomes armed.
- R10: If no value is queued when a match happens, the channel is left disarmed and no further match occurs. The next compare write arms it directly.
- R11: In a cycle where the counter-wrap input is high, a match counts only if the wrap-event enable input is high.
- R12: A status/control write with mode 0 disables the channel. It drops both compare slots and drives the pin low, so the old armed value does not match later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_val | input | CNT_W | Current value of the timestamp counter |
| cnt_wrap | input | 1 | High in the cycle the counter has just wrapped its period |
| ovf_evt_en | input | 1 | Allows a match in a wrap cycle |
| csr_wr | input | 1 | Write strobe for the status/control word |
| csr_wdata | input | 8 | Status/control write data |
| csr_rdata | output | 8 | Status/control readback |
| cmp_wr | input | 1 | Write strobe for the compare value |
| cmp_wdata | input | CNT_W | Compare value write data |
| cmp_rdata | output | CNT_W | Currently armed compare value |
| irq | output | 1 | Interrupt request |
| pin_out | output | 1 | Channel output pin |

## Verification
The bench builds the channel with an 8-bit counter width and a 3-cycle pulse. This lets compare values, the wrap-cycle case and the complete end of a pulse all be driven directly, cycle by cycle, within a few dozen clocks. The counter input is set explicitly each cycle, so matches at chosen values, repeated hits on a spent value, and matches against a cleared queue all take place at known edges.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;
  localparam int CSR_W = 8;

  // status/control bit positions
  localparam int B_DREQ = 0;
  localparam int B_MODE_LO = 2;
  localparam int B_IE = 6;
  localparam int B_FLAG = 7;

  localparam logic [3:0] MODE_OFF    = 4'h0;
  localparam logic [3:0] MODE_TOGGLE = 4'h5;
  localparam logic [3:0] MODE_PULSE  = 4'hF;

  function automatic logic [CSR_W-1:0] csr_pack(input logic dreq, input logic [3:0] mode,
                                                input logic ie, input logic flag);
    logic [CSR_W-1:0] w;
    w = '0;
    w[B_DREQ] = dreq;
    w[B_MODE_LO +: 4] = mode;
    w[B_IE] = ie;
    w[B_FLAG] = flag;
    return w;
  endfunction

  function automatic logic [3:0] csr_mode(input logic [CSR_W-1:0] w);
    return w[B_MODE_LO +: 4];
  endfunction
endpackage

// File: rtl/tcmp_ctrl.sv
module tcmp_ctrl
  import tcmp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_wr,
  input  logic [CSR_W-1:0] csr_wdata,
  input  logic             ev_match,
  output logic [CSR_W-1:0] csr_rdata,
  output logic [3:0]       mode,
  output logic             ie,
  output logic             flag,
  output logic             dis_req
);
  logic dreq_en;

  assign dis_req = csr_wr && (csr_mode(csr_wdata) == MODE_OFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dreq_en <= 1'b0;
      mode    <= MODE_OFF;
      ie      <= 1'b0;
      flag    <= 1'b0;
    end else begin
      if (csr_wr) begin
        dreq_en <= csr_wdata[B_DREQ];
        mode    <= csr_mode(csr_wdata);
        ie      <= csr_wdata[B_IE];
      end
      if (ev_match)
        flag <= 1'b1;
      else if (csr_wr && csr_wdata[B_FLAG])
        flag <= 1'b0;
    end
  end

  assign csr_rdata = csr_pack(dreq_en, mode, ie, flag);

  // R5
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_match |=> flag);
  // R3
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && csr_wdata[B_FLAG] && !ev_match) |=> !flag);
endmodule

// File: rtl/tcmp_slots.sv
module tcmp_slots
  import tcmp_pkg::*;
#(
  parameter int CNT_W = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic [3:0]       mode,
  input  logic             dis_req,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_wrap,
  input  logic             ovf_evt_en,
  output logic             ev_match,
  output logic [CNT_W-1:0] armed_val
);
  logic             a_vld, q_vld;
  logic [CNT_W-1:0] queued;

  function automatic logic fires(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] a,
                                 input logic wrap, input logic ovf_ok);
    return (c == a) && (!wrap || ovf_ok);
  endfunction

  assign ev_match = (mode != MODE_OFF) && a_vld && fires(cnt_val, armed_val, cnt_wrap, ovf_evt_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_vld     <= 1'b0;
      q_vld     <= 1'b0;
      armed_val <= '0;
      queued    <= '0;
    end else if (dis_req) begin
      a_vld <= 1'b0;
      q_vld <= 1'b0;
    end else if (ev_match) begin
      if (q_vld) begin
        armed_val <= queued;
        a_vld     <= 1'b1;
        q_vld     <= cmp_wr;
        if (cmp_wr) queued <= cmp_wdata;
      end else if (cmp_wr) begin
        armed_val <= cmp_wdata;
        a_vld     <= 1'b1;
      end else begin
        a_vld <= 1'b0;
      end
    end else if (cmp_wr) begin
      if (mode == MODE_OFF || !a_vld) begin
        armed_val <= cmp_wdata;
        a_vld     <= 1'b1;
      end else begin
        queued <= cmp_wdata;
        q_vld  <= 1'b1;
      end
    end
  end

  // R9
  promote_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_match && q_vld && !dis_req) |=> (a_vld && armed_val == $past(queued)));
  // R10
  no_requeue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_match && !q_vld && !cmp_wr && !dis_req) |=> !a_vld);
  // R12
  dis_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dis_req |=> (!a_vld && !q_vld && !ev_match));
endmodule

// File: rtl/tcmp_pinout.sv
module tcmp_pinout
  import tcmp_pkg::*;
#(
  parameter int PULSE_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] mode,
  input  logic       ev_match,
  input  logic       dis_req,
  output logic       pin
);
  localparam int PW = $clog2(PULSE_LEN + 1);
  localparam logic [PW-1:0] PLEN = PW'(PULSE_LEN);

  logic          tog_q;
  logic [PW-1:0] pulse_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || dis_req) begin
      tog_q     <= 1'b0;
      pulse_cnt <= '0;
    end else begin
      if (ev_match && mode == MODE_TOGGLE)
        tog_q <= !tog_q;
      if (ev_match && mode == MODE_PULSE)
        pulse_cnt <= PLEN;
      else if (pulse_cnt != '0)
        pulse_cnt <= pulse_cnt - 1'b1;
    end
  end

  always_comb begin
    case (mode)
      MODE_TOGGLE: pin = tog_q;
      MODE_PULSE:  pin = (pulse_cnt != '0);
      default:     pin = 1'b0;
    endcase
  end

  // R6
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_match && mode == MODE_TOGGLE && !dis_req) |=> (tog_q != $past(tog_q)));
  // R7
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_cnt <= PLEN);
endmodule

// File: rtl/tcmp_channel.sv
module tcmp_channel
  import tcmp_pkg::*;
#(
  parameter int CNT_W     = 31,
  parameter int PULSE_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_wrap,
  input  logic             ovf_evt_en,
  input  logic             csr_wr,
  input  logic [7:0]       csr_wdata,
  output logic [7:0]       csr_rdata,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  output logic [CNT_W-1:0] cmp_rdata,
  output logic             irq,
  output logic             pin_out
);
  logic       ev_match, dis_req, flag, ie;
  logic [3:0] mode;

  tcmp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .ev_match(ev_match), .csr_rdata(csr_rdata), .mode(mode), .ie(ie),
    .flag(flag), .dis_req(dis_req)
  );

  tcmp_slots #(.CNT_W(CNT_W)) u_slots (
    .clk(clk), .rst_n(rst_n), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .mode(mode), .dis_req(dis_req), .cnt_val(cnt_val), .cnt_wrap(cnt_wrap),
    .ovf_evt_en(ovf_evt_en), .ev_match(ev_match), .armed_val(cmp_rdata)
  );

  tcmp_pinout #(.PULSE_LEN(PULSE_LEN)) u_pin (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ev_match(ev_match),
    .dis_req(dis_req), .pin(pin_out)
  );

  assign irq = flag && ie;

  // R4
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (csr_rdata[B_FLAG] && csr_rdata[B_IE]));
endmodule

// File: tb/sim_tcmp_channel.sv
module sim_tcmp_channel;
  localparam int CW = 8;
  localparam int PL = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] cnt_val = '0;
  logic          cnt_wrap = 1'b0;
  logic          ovf_evt_en = 1'b0;
  logic          csr_wr = 1'b0;
  logic [7:0]    csr_wdata = '0;
  logic [7:0]    csr_rdata;
  logic          cmp_wr = 1'b0;
  logic [CW-1:0] cmp_wdata = '0;
  logic [CW-1:0] cmp_rdata;
  logic          irq, pin_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = !clk;

  tcmp_channel #(.CNT_W(CW), .PULSE_LEN(PL)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_wrap(cnt_wrap),
    .ovf_evt_en(ovf_evt_en), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .cmp_rdata(cmp_rdata), .irq(irq), .pin_out(pin_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    csr_wr = 1'b0;
    cmp_wr = 1'b0;
    cnt_wrap = 1'b0;
  endtask

  task automatic wr_csr(input logic [7:0] v);
    csr_wr = 1'b1; csr_wdata = v; tick();
  endtask

  task automatic wr_cmp(input logic [CW-1:0] v);
    cmp_wr = 1'b1; cmp_wdata = v; tick();
  endtask

  task automatic at_cnt(input logic [CW-1:0] v);
    cnt_val = v; tick();
  endtask

  task automatic t_reset();
    chk(csr_rdata == 8'h00, "R1 csr", csr_rdata, 0);
    chk(!irq && !pin_out, "R1 irq/pin", {irq, pin_out}, 0);
  endtask

  task automatic t_fields();
    wr_csr(8'h45);
    chk(csr_rdata == 8'h45, "R2 fields", csr_rdata, 8'h45);
    chk(!irq, "R4 irq without flag", irq, 0);
    wr_csr(8'h00);
    chk(csr_rdata == 8'h00, "R2 clear", csr_rdata, 0);
  endtask

  task automatic t_toggle();
    wr_cmp(8'd10);
    chk(cmp_rdata == 8'd10, "R8 armed", cmp_rdata, 10);
    wr_csr(8'h54);
    wr_cmp(8'd20);
    chk(cmp_rdata == 8'd10, "R9 queued not armed", cmp_rdata, 10);
    at_cnt(8'd9);
    chk(!csr_rdata[7] && !pin_out, "R5 no early match", {csr_rdata[7], pin_out}, 0);
    at_cnt(8'd10);
    chk(csr_rdata[7], "R5 flag", csr_rdata[7], 1);
    chk(pin_out, "R6 toggle high", pin_out, 1);
    chk(irq, "R4 irq", irq, 1);
    chk(cmp_rdata == 8'd20, "R9 promoted", cmp_rdata, 20);
    wr_csr(8'h14);
    chk(csr_rdata[7], "R3 zero bit keeps flag", csr_rdata[7], 1);
    wr_csr(8'hD4);
    chk(csr_rdata == 8'h54 && !irq, "R3 w1c", csr_rdata, 8'h54);
    at_cnt(8'd20);
    chk(!pin_out && csr_rdata[7], "R6 toggle low", {pin_out, csr_rdata[7]}, 1);
    wr_csr(8'hD4);
    at_cnt(8'd21);
    at_cnt(8'd20);
    chk(!csr_rdata[7] && !pin_out, "R10 disarmed", {csr_rdata[7], pin_out}, 0);
    wr_cmp(8'd40);
    chk(cmp_rdata == 8'd40, "R10 direct arm", cmp_rdata, 40);
    at_cnt(8'd40);
    chk(csr_rdata[7] && pin_out, "R10 rearmed match", {csr_rdata[7], pin_out}, 3);
  endtask

  task automatic t_pulse();
    wr_csr(8'h80);
    chk(!pin_out && csr_rdata == 8'h00, "R12 off pin low", {pin_out, csr_rdata}, 0);
    wr_cmp(8'd50);
    wr_csr(8'h3C);
    wr_cmp(8'd60);
    at_cnt(8'd50);
    chk(pin_out, "R7 pulse start", pin_out, 1);
    chk(!irq && csr_rdata[7], "R4 no irq when disabled", irq, 0);
    at_cnt(8'd51);
    chk(pin_out, "R7 pulse cycle 2", pin_out, 1);
    at_cnt(8'd52);
    chk(pin_out, "R7 pulse cycle 3", pin_out, 1);
    at_cnt(8'd53);
    chk(!pin_out, "R7 pulse end", pin_out, 0);
    at_cnt(8'd60);
    chk(pin_out && cmp_rdata == 8'd60, "R9 second pulse", pin_out, 1);
  endtask

  task automatic t_wrap();
    wr_csr(8'h80);
    wr_cmp(8'd0);
    wr_csr(8'h3C);
    ovf_evt_en = 1'b0;
    cnt_wrap = 1'b1; cnt_val = 8'd0; @(negedge clk); cnt_wrap = 1'b0;
    chk(!csr_rdata[7], "R11 wrap blocked", csr_rdata[7], 0);
    cnt_val = 8'd5; tick();
    ovf_evt_en = 1'b1;
    cnt_wrap = 1'b1; cnt_val = 8'd0; @(negedge clk); cnt_wrap = 1'b0;
    chk(csr_rdata[7] && pin_out, "R11 wrap allowed", csr_rdata[7], 1);
  endtask

  task automatic t_disable();
    wr_csr(8'h80);
    wr_cmp(8'd70);
    wr_csr(8'h14);
    wr_csr(8'h00);
    wr_csr(8'h14);
    at_cnt(8'd70);
    chk(!csr_rdata[7] && !pin_out, "R12 slots dropped", {csr_rdata[7], pin_out}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_fields();
    t_toggle();
    t_pulse();
    t_wrap();
    t_disable();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule